// File: doc/BRIEF.md
# Framebuffer rectangle fill and copy engine

This block carries out two drawing commands on a byte-addressed framebuffer held in an external synchronous RAM with a one-cycle read latency. A **fill** paints a rectangle with a 32-bit colour. A **copy** moves a rectangle to another position in the same memory, and the result is correct even when the source and destination areas overlap. The pixel size (1 to 4 bytes) and the screen width in pixels come from configuration inputs. The line pitch is the pixel size multiplied by the screen width.

The engine accepts a command only while it is idle. It works one byte at a time. A fill writes its first row straight from the colour register, one byte per cycle. It then makes every other row by reading the first row back and writing it one pitch further down. A copy reads and writes each byte in turn. The order of its rows, and of the bytes within a row, is chosen so that no byte is overwritten before it has been read.

When a command finishes, the destination rectangle is appended to a circular damage queue. The display side pops entries from this queue. The display side can also discard all pending entries in one step when it is going to redraw the whole screen.

Top module: `rect_blit_engine`

## Requirements
- R1: After reset, `cmd_ready` is 1, `done` is 0, `dmg_valid` is 0, and neither memory enable is active.
- R2: The byte address of pixel (x, y) is bypp*x + (bypp*scr_w)*y, where bypp is `cfg_bypp` (1 to 4) and scr_w is `cfg_scr_w`. Both are sampled when the command is accepted.
- R3: A fill (`cmd_copy`=0) writes colour byte k mod bypp at byte offset k of each row. Colour byte 0 is `cmd_color[7:0]`, and higher bytes follow in ascending order.
- R4: A fill writes its first row one byte per cycle. It then builds each remaining row with a read cycle and a write cycle per byte. `done` rises n + 2n(h-1) + 2 cycles after the accepting edge, where n = bypp*w.
- R5: When w or h is zero, the command writes no memory. The rectangle is still queued, and `done` rises 2 cycles after the accepting edge.
- R6: A copy (`cmd_copy`=1) with destination y greater than source y processes rows from h-1 down to 0. Any other copy processes rows from 0 up to h-1. In both cases the destination ends up equal to the original source rectangle, including when the two overlap. `done` rises 2nh + 2 cycles after the accepting edge.
- R7: When a copy's source and destination share the same y and the destination x is greater than the source x, each row is moved starting from its last byte. An overlapping shift to the right or to the left gives the original source bytes.
- R8: When a command finishes, its destination x, y, w and h are written at the write index of a 512-entry ring. The queue entry appears in the same cycle in which `done` is high. `dmg_valid` is 1 whenever the read and write indices differ, and the `dmg_*` fields then show the entry at the read index. A pulse on `dmg_pop` advances the read index. Both indices wrap modulo 512, so after 512 unread entries the queue reads as empty and later entries are read from slot 0.
- R9: A pulse on `dmg_drop_all` sets the read index equal to the write index. If no entry is being added in that cycle, `dmg_valid` is 0 in the next cycle. `dmg_drop_all` takes priority over `dmg_pop`.
- R10: `done` is a single-cycle pulse that follows the cycle in which the queue entry was written. A `cmd_valid` seen while the engine is busy is ignored: it changes neither the memory, nor the queue, nor the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bypp | input | 3 | Bytes per pixel, 1 to 4 |
| cfg_scr_w | input | COORD_W | Screen width in pixels |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine is idle and accepts a command |
| cmd_copy | input | 1 | 1 = copy, 0 = fill |
| cmd_color | input | 32 | Fill colour |
| cmd_src_x | input | COORD_W | Copy source x |
| cmd_src_y | input | COORD_W | Copy source y |
| cmd_dst_x | input | COORD_W | Destination x |
| cmd_dst_y | input | COORD_W | Destination y |
| cmd_w | input | COORD_W | Width in pixels |
| cmd_h | input | COORD_W | Height in rows |
| mem_rd_en | output | 1 | RAM read strobe |
| mem_rd_addr | output | ADDR_W | RAM read byte address |
| mem_rd_data | input | 8 | RAM read data, one cycle after the strobe |
| mem_wr_en | output | 1 | RAM write strobe |
| mem_wr_addr | output | ADDR_W | RAM write byte address |
| mem_wr_data | output | 8 | RAM write data |
| done | output | 1 | One-cycle completion pulse |
| dmg_valid | output | 1 | Damage queue is not empty |
| dmg_x | output | COORD_W | Head entry x |
| dmg_y | output | COORD_W | Head entry y |
| dmg_w | output | COORD_W | Head entry width |
| dmg_h | output | COORD_W | Head entry height |
| dmg_pop | input | 1 | Remove the head entry |
| dmg_drop_all | input | 1 | Discard every pending entry |

## Verification
Each command has a fixed duration, set by its kind and its size. The bench computes the completion cycle from R4, R5 and R6 and counts clock cycles from the accepting edge. In every one of those cycles it compares `cmd_ready`, `done` and the damage-queue outputs against a behavioural model. A queue update caused by a pop or a drop is expected in the cycle right after the request, and a new entry is expected in the cycle in which `done` is high. The framebuffer contents are compared in full against a snapshot-based reference once each command has completed.

// File: rtl/rbe_pkg.sv
package rbe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_RD,
        ST_WR,
        ST_PUSH,
        ST_DONE
    } rbe_state_e;

endpackage

// File: rtl/rbe_addr_gen.sv
module rbe_addr_gen #(
    parameter int COORD_W = 12,
    parameter int ADDR_W  = 16
) (
    input  logic [2:0]           bypp,
    input  logic [COORD_W+2:0]   pitch,
    input  logic [COORD_W-1:0]   x,
    input  logic [COORD_W-1:0]   y,
    input  logic [COORD_W+2:0]   off,
    output logic [ADDR_W-1:0]    addr
);
    localparam int SUM_W = 2 * COORD_W + 5;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = SUM_W'(bypp) * SUM_W'(x) + SUM_W'(pitch) * SUM_W'(y) + SUM_W'(off);
    end

    generate
        if (SUM_W >= ADDR_W) begin : g_trunc
            assign addr = sum[ADDR_W-1:0];
        end else begin : g_ext
            assign addr = {{(ADDR_W - SUM_W){1'b0}}, sum};
        end
    endgenerate

endmodule

// File: rtl/rbe_dmg_ring.sv
module rbe_dmg_ring #(
    parameter int DEPTH = 512,
    parameter int EW    = 48
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [EW-1:0] push_data,
    input  logic          pop,
    input  logic          drop_all,
    output logic          valid,
    output logic [EW-1:0] head
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
    } ring_t;

    ring_t r_q, r_d;
    logic [EW-1:0] ent_q [DEPTH];

    // Indices are AW bits wide, so incrementing them wraps like masking with DEPTH-1.
    always_comb begin
        r_d = r_q;
        if (push)
            r_d.wr = r_q.wr + 1'b1;
        if (drop_all)
            r_d.rd = r_q.wr;
        else if (pop && (r_q.rd != r_q.wr))
            r_d.rd = r_q.rd + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (push)
            ent_q[r_q.wr] <= push_data;
    end

    assign valid = (r_q.rd != r_q.wr);
    assign head  = ent_q[r_q.rd];

    assert_drop_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        drop_all && !push |=> !valid);

    assert_push_fills_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push && !valid && !drop_all |=> valid);

    assert_pop_empty_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid && pop && !push |=> !valid);

endmodule

// File: rtl/rect_blit_engine.sv
module rect_blit_engine
    import rbe_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int COORD_W  = 12,
    parameter int DQ_DEPTH = 512
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         cfg_bypp,
    input  logic [COORD_W-1:0] cfg_scr_w,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic               cmd_copy,
    input  logic [31:0]        cmd_color,
    input  logic [COORD_W-1:0] cmd_src_x,
    input  logic [COORD_W-1:0] cmd_src_y,
    input  logic [COORD_W-1:0] cmd_dst_x,
    input  logic [COORD_W-1:0] cmd_dst_y,
    input  logic [COORD_W-1:0] cmd_w,
    input  logic [COORD_W-1:0] cmd_h,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    input  logic [7:0]         mem_rd_data,
    output logic               mem_wr_en,
    output logic [ADDR_W-1:0]  mem_wr_addr,
    output logic [7:0]         mem_wr_data,
    output logic               done,
    output logic               dmg_valid,
    output logic [COORD_W-1:0] dmg_x,
    output logic [COORD_W-1:0] dmg_y,
    output logic [COORD_W-1:0] dmg_w,
    output logic [COORD_W-1:0] dmg_h,
    input  logic               dmg_pop,
    input  logic               dmg_drop_all
);
    localparam int CW = COORD_W;
    localparam int BW = COORD_W + 3;   // byte counts within a row
    localparam int EW = 4 * COORD_W;   // one damage entry

    typedef struct packed {
        rbe_state_e     st;
        logic           copy;
        logic [31:0]    color;
        logic [2:0]     bypp;
        logic [BW-1:0]  pitch;
        logic [CW-1:0]  sx;
        logic [CW-1:0]  sy;
        logic [CW-1:0]  dx;
        logic [CW-1:0]  dy;
        logic [CW-1:0]  w;
        logic [CW-1:0]  h;
        logic [BW-1:0]  rowbytes;
        logic [CW-1:0]  r;      // logical row counter
        logic [BW-1:0]  b;      // logical byte counter
        logic [1:0]     ph;     // colour byte phase
        logic           up;     // rows from the bottom
        logic           rev;    // bytes from the right
    } eng_t;

    eng_t s_q, s_d;
    logic push;

    // Physical row and byte derived from the logical counters and the chosen order.
    logic [CW-1:0] act_row;
    logic [BW-1:0] act_byte;
    logic [CW-1:0] src_row;
    logic [CW-1:0] dst_row;
    logic          last_byte;
    logic          last_row;

    always_comb begin
        act_row   = s_q.up  ? (s_q.h - 1'b1 - s_q.r) : s_q.r;
        act_byte  = s_q.rev ? (s_q.rowbytes - 1'b1 - s_q.b) : s_q.b;
        src_row   = s_q.copy ? (s_q.sy + act_row) : s_q.sy;
        dst_row   = s_q.dy + act_row;
        last_byte = (s_q.b == s_q.rowbytes - 1'b1);
        last_row  = (s_q.r == s_q.h - 1'b1);
    end

    rbe_addr_gen #(.COORD_W(COORD_W), .ADDR_W(ADDR_W)) u_src_addr (
        .bypp  (s_q.bypp),
        .pitch (s_q.pitch),
        .x     (s_q.sx),
        .y     (src_row),
        .off   (act_byte),
        .addr  (mem_rd_addr)
    );

    rbe_addr_gen #(.COORD_W(COORD_W), .ADDR_W(ADDR_W)) u_dst_addr (
        .bypp  (s_q.bypp),
        .pitch (s_q.pitch),
        .x     (s_q.dx),
        .y     (dst_row),
        .off   (act_byte),
        .addr  (mem_wr_addr)
    );

    always_comb begin
        s_d  = s_q;
        push = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    s_d.copy     = cmd_copy;
                    s_d.color    = cmd_color;
                    s_d.bypp     = cfg_bypp;
                    s_d.pitch    = BW'(cfg_bypp) * BW'(cfg_scr_w);
                    s_d.rowbytes = BW'(cfg_bypp) * BW'(cmd_w);
                    s_d.dx       = cmd_dst_x;
                    s_d.dy       = cmd_dst_y;
                    s_d.w        = cmd_w;
                    s_d.h        = cmd_h;
                    s_d.sx       = cmd_copy ? cmd_src_x : cmd_dst_x;
                    s_d.sy       = cmd_copy ? cmd_src_y : cmd_dst_y;
                    s_d.r        = '0;
                    s_d.b        = '0;
                    s_d.ph       = '0;
                    s_d.up       = cmd_copy && (cmd_dst_y > cmd_src_y);
                    s_d.rev      = cmd_copy && (cmd_dst_y == cmd_src_y) && (cmd_dst_x > cmd_src_x);
                    if ((cmd_w == '0) || (cmd_h == '0))
                        s_d.st = ST_PUSH;
                    else if (cmd_copy)
                        s_d.st = ST_RD;
                    else
                        s_d.st = ST_FILL;
                end
            end
            ST_FILL: begin
                s_d.ph = (s_q.ph == 2'(s_q.bypp - 3'd1)) ? 2'd0 : s_q.ph + 2'd1;
                if (last_byte) begin
                    s_d.b = '0;
                    if (last_row) begin
                        s_d.st = ST_PUSH;
                    end else begin
                        s_d.r  = CW'(1);
                        s_d.st = ST_RD;
                    end
                end else begin
                    s_d.b = s_q.b + 1'b1;
                end
            end
            ST_RD: begin
                s_d.st = ST_WR;
            end
            ST_WR: begin
                if (last_byte) begin
                    s_d.b = '0;
                    if (last_row) begin
                        s_d.st = ST_PUSH;
                    end else begin
                        s_d.r  = s_q.r + 1'b1;
                        s_d.st = ST_RD;
                    end
                end else begin
                    s_d.b  = s_q.b + 1'b1;
                    s_d.st = ST_RD;
                end
            end
            ST_PUSH: begin
                push   = 1'b1;
                s_d.st = ST_DONE;
            end
            ST_DONE: begin
                s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_ready   = (s_q.st == ST_IDLE);
    assign done        = (s_q.st == ST_DONE);
    assign mem_rd_en   = (s_q.st == ST_RD);
    assign mem_wr_en   = (s_q.st == ST_FILL) || (s_q.st == ST_WR);
    assign mem_wr_data = (s_q.st == ST_FILL) ? s_q.color[{s_q.ph, 3'b000} +: 8] : mem_rd_data;

    logic [EW-1:0] head;

    rbe_dmg_ring #(.DEPTH(DQ_DEPTH), .EW(EW)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data ({s_q.dx, s_q.dy, s_q.w, s_q.h}),
        .pop       (dmg_pop),
        .drop_all  (dmg_drop_all),
        .valid     (dmg_valid),
        .head      (head)
    );

    assign {dmg_x, dmg_y, dmg_w, dmg_h} = head;

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !mem_wr_en && !mem_rd_en);

    assert_accept_leaves_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready && cmd_valid |=> !cmd_ready);

    assert_done_after_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(push));

    assert_read_then_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> mem_wr_en && !mem_rd_en);

endmodule

// File: tb/rect_blit_engine_tb_top.sv
module rect_blit_engine_tb_top;
    localparam int AW    = 12;
    localparam int CW    = 12;
    localparam int MEMSZ = 4096;
    localparam int QD    = 512;
    localparam int SCRW  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [2:0]    cfg_bypp = 3'd1;
    logic [CW-1:0] cfg_scr_w = CW'(SCRW);
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic          cmd_copy = 1'b0;
    logic [31:0]   cmd_color = '0;
    logic [CW-1:0] cmd_src_x = '0, cmd_src_y = '0, cmd_dst_x = '0, cmd_dst_y = '0;
    logic [CW-1:0] cmd_w = '0, cmd_h = '0;
    logic          mem_rd_en, mem_wr_en;
    logic [AW-1:0] mem_rd_addr, mem_wr_addr;
    logic [7:0]    mem_rd_data, mem_wr_data;
    logic          done, dmg_valid;
    logic [CW-1:0] dmg_x, dmg_y, dmg_w, dmg_h;
    logic          dmg_pop = 1'b0, dmg_drop_all = 1'b0;

    rect_blit_engine #(.ADDR_W(AW), .COORD_W(CW), .DQ_DEPTH(QD)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_bypp(cfg_bypp), .cfg_scr_w(cfg_scr_w),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_copy(cmd_copy),
        .cmd_color(cmd_color), .cmd_src_x(cmd_src_x), .cmd_src_y(cmd_src_y),
        .cmd_dst_x(cmd_dst_x), .cmd_dst_y(cmd_dst_y), .cmd_w(cmd_w), .cmd_h(cmd_h),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .done(done), .dmg_valid(dmg_valid), .dmg_x(dmg_x), .dmg_y(dmg_y),
        .dmg_w(dmg_w), .dmg_h(dmg_h), .dmg_pop(dmg_pop), .dmg_drop_all(dmg_drop_all)
    );

    // Framebuffer RAM: synchronous, one cycle read latency.
    logic [7:0] fb [MEMSZ];
    always @(posedge clk) begin
        if (mem_wr_en) fb[mem_wr_addr] <= mem_wr_data;
        if (mem_rd_en) mem_rd_data <= fb[mem_rd_addr];
    end

    // Reference model state.
    int ref_mem [MEMSZ];
    int tmp [MEMSZ];
    int m_x [QD], m_y [QD], m_w [QD], m_h [QD];
    int m_rd = 0, m_wr = 0;
    bit exp_ready = 1'b1, exp_done = 1'b0;
    string cur_req = "R1";
    int n_checks = 0, n_fail = 0;
    bit finished = 1'b0;

    function automatic int fbaddr(int bp, int x, int y);
        return bp * x + bp * SCRW * y;
    endfunction

    task automatic tick();
        bit exp_valid;
        @(negedge clk);
        exp_valid = (m_rd != m_wr);
        n_checks++;
        if (cmd_ready !== exp_ready || done !== exp_done || dmg_valid !== exp_valid) begin
            n_fail++;
            $display("FAIL %s: ready/done/valid actual %b%b%b expected %b%b%b at %0t",
                     cur_req, cmd_ready, done, dmg_valid, exp_ready, exp_done, exp_valid, $time);
        end else if (exp_valid && (int'(dmg_x) != m_x[m_rd] || int'(dmg_y) != m_y[m_rd] ||
                                   int'(dmg_w) != m_w[m_rd] || int'(dmg_h) != m_h[m_rd])) begin
            n_fail++;
            $display("FAIL %s: head actual %0d,%0d,%0d,%0d expected %0d,%0d,%0d,%0d",
                     cur_req, dmg_x, dmg_y, dmg_w, dmg_h,
                     m_x[m_rd], m_y[m_rd], m_w[m_rd], m_h[m_rd]);
        end
    endtask

    task automatic check_mem();
        int bad = 0;
        int first = -1;
        for (int i = 0; i < MEMSZ; i++)
            if (int'(fb[i]) != ref_mem[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        n_checks++;
        if (bad != 0) begin
            n_fail++;
            $display("FAIL %s: framebuffer byte %0d actual %0h expected %0h (%0d bad)",
                     cur_req, first, fb[first], ref_mem[first], bad);
        end
    endtask

    task automatic run_cmd(input bit cp, input logic [31:0] col, input int bp,
                           input int sx, input int sy, input int dx, input int dy,
                           input int w, input int h, input bit inject, input string req);
        int n, t;
        cur_req = req;
        n = bp * w;
        if (w == 0 || h == 0) t = 2;
        else if (cp) t = 2 * n * h + 2;
        else t = n + 2 * n * (h - 1) + 2;
        // reference memory update
        if (w != 0 && h != 0) begin
            if (cp) begin
                for (int r = 0; r < h; r++)
                    for (int b = 0; b < n; b++)
                        tmp[r * n + b] = ref_mem[fbaddr(bp, sx, sy + r) + b];
                for (int r = 0; r < h; r++)
                    for (int b = 0; b < n; b++)
                        ref_mem[fbaddr(bp, dx, dy + r) + b] = tmp[r * n + b];
            end else begin
                for (int r = 0; r < h; r++)
                    for (int b = 0; b < n; b++)
                        ref_mem[fbaddr(bp, dx, dy + r) + b] = int'(col[8 * (b % bp) +: 8]);
            end
        end
        cfg_bypp  = 3'(bp);
        cmd_copy  = cp;
        cmd_color = col;
        cmd_src_x = CW'(sx); cmd_src_y = CW'(sy);
        cmd_dst_x = CW'(dx); cmd_dst_y = CW'(dy);
        cmd_w = CW'(w); cmd_h = CW'(h);
        cmd_valid = 1'b1;
        exp_ready = 1'b0;
        for (int c = 1; c <= t; c++) begin
            exp_done = (c == t);
            if (c == t) begin
                m_x[m_wr] = dx; m_y[m_wr] = dy; m_w[m_wr] = w; m_h[m_wr] = h;
                m_wr = (m_wr + 1) % QD;
            end
            tick();
            cmd_valid = 1'b0;
            if (inject && c == 1) begin
                // R10: a request while busy must be ignored
                cmd_valid = 1'b1; cmd_copy = 1'b0; cmd_color = 32'hDEADBEEF;
                cmd_dst_x = '0; cmd_dst_y = '0; cmd_w = CW'(4); cmd_h = CW'(4);
            end
        end
        cmd_valid = 1'b0;
        exp_done  = 1'b0;
        exp_ready = 1'b1;
        tick();
        check_mem();
    endtask

    task automatic pop_one(input string req);
        cur_req = req;
        dmg_pop = 1'b1;
        if (m_rd != m_wr) m_rd = (m_rd + 1) % QD;
        tick();
        dmg_pop = 1'b0;
    endtask

    task automatic drop_all(input string req);
        cur_req = req;
        dmg_drop_all = 1'b1;
        m_rd = m_wr;
        tick();
        dmg_drop_all = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < MEMSZ; i++) begin
            fb[i] = 8'((i * 7 + 3) & 255);
            ref_mem[i] = (i * 7 + 3) & 255;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cur_req = "R1";
        tick();
        n_checks++;
        if (mem_rd_en !== 1'b0 || mem_wr_en !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: mem enables actual %b%b expected 00", mem_rd_en, mem_wr_en);
        end
        tick();
        // R2 R3 R4: fills at several pixel sizes
        run_cmd(1'b0, 32'hA1B2C3D4, 4, 0, 0, 2, 3, 3, 4, 1'b0, "R3");
        run_cmd(1'b0, 32'h00112233, 3, 0, 0, 5, 1, 5, 2, 1'b0, "R2");
        run_cmd(1'b0, 32'h0000005A, 1, 0, 0, 9, 20, 7, 1, 1'b0, "R4");
        // R5: empty rectangles
        run_cmd(1'b0, 32'hFFFFFFFF, 2, 0, 0, 1, 1, 4, 0, 1'b0, "R5");
        run_cmd(1'b0, 32'hFFFFFFFF, 2, 0, 0, 1, 1, 0, 3, 1'b0, "R5");
        // R8: pop entries while checking the head
        for (int i = 0; i < 3; i++) pop_one("R8");
        // R6: overlapping copies in both vertical directions
        run_cmd(1'b1, '0, 2, 1, 2, 3, 5, 6, 5, 1'b0, "R6");
        run_cmd(1'b1, '0, 2, 4, 8, 2, 5, 6, 6, 1'b0, "R6");
        run_cmd(1'b1, '0, 4, 0, 2, 4, 20, 5, 3, 1'b0, "R6");
        // R7: same-row overlapping shifts right and left
        run_cmd(1'b1, '0, 2, 2, 10, 5, 10, 8, 3, 1'b0, "R7");
        run_cmd(1'b1, '0, 3, 6, 12, 3, 12, 8, 2, 1'b0, "R7");
        // R10: request during busy is ignored
        run_cmd(1'b0, 32'h0F1E2D3C, 2, 0, 0, 10, 25, 3, 2, 1'b1, "R10");
        // R9: drop everything pending
        drop_all("R9");
        tick();
        pop_one("R9");
        // R8: ring wraps after 512 entries
        for (int i = 0; i < 515; i++)
            run_cmd(1'b0, '0, 1, 0, 0, i, 0, 0, 0, 1'b0, "R8");
        for (int i = 0; i < 4; i++) pop_one("R8");
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule